// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table held in memory. When a miss arrives it records the missing virtual page number, the kind of access that was attempted and the base address of the page directory. It then reads one directory entry and, if that entry is valid, one table entry from the page that the directory entry points at. Each walk ends in one of three ways: a segmentation fault, a protection fault, or a fill strobe that carries the page number, frame number and permission bits for the translation cache. A fill also tells the core to retry the faulting instruction.

The memory side is a single-outstanding request/response port. A read is one request pulse with an address. The memory can take any number of cycles to return a valid response with the entry word. The walker accepts one miss at a time. While a walk is in progress it raises a busy flag and ignores further miss strobes. The translation cache itself and any caching of directory entries are not part of this block.

Entry word layout (both levels, 32 bits): bit 0 is the valid flag, bits 3:1 are the permission bits {execute, write, read}, and bits 17:8 hold the 10-bit frame number. The default geometry is a 14-bit virtual address with 64-byte pages and 4-byte entries. That gives an 8-bit page number, split into a 4-bit directory index (bits 7:4) and a 4-bit table index (bits 3:0).

Top module: `ptw_walker`

## Requirements
- R1: During and after synchronous reset, with no miss presented, busy, mem_req_o, done_o and fill_o are 0 and fault_o is 0.
- R2: The first read of a walk goes to pdbr + 4 * vpn[7:4], using the pdbr value present when the miss was accepted.
- R3: A directory entry with bit 0 clear ends the walk with fault code 1 (segmentation). Exactly one memory read is made for that walk.
- R4: After a valid directory entry, the second read goes to (entry[17:8] << 6) + 4 * vpn[3:0].
- R5: A table entry with bit 0 clear ends the walk with fault code 1 and no fill.
- R6: Access codes are 0 for read (needs bit 1), 1 for write (needs bit 2) and 2 for execute (needs bit 3). Code 3 is never permitted. A valid table entry that lacks the needed bit ends the walk with fault code 2 (protection) and no fill.
- R7: Otherwise the walk ends with fill_o high, fault code 0, fill_vpn_o equal to the missing page number, fill_pfn_o equal to table entry bits 17:8, and fill_prot_o equal to table entry bits 3:1.
- R8: done_o is a single-cycle pulse that rises one cycle after the final response of the walk is presented. fault_o is nonzero and fill_o is high only in that cycle.
- R9: busy_o rises the cycle after a miss is accepted and falls in the done cycle. A miss strobe seen while busy is ignored and does not start a walk or change the result.
- R10: Each read is a one-cycle request pulse. The walker then waits for mem_rsp_valid_i, whatever the latency, and never has more than one read outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid_i | input | 1 | Miss strobe, taken only when idle |
| miss_vpn_i | input | 8 | Missing virtual page number |
| miss_acc_i | input | 2 | Access code: 0 read, 1 write, 2 execute |
| pdbr_i | input | 16 | Page directory base address |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Read request pulse |
| mem_addr_o | output | 16 | Read byte address |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_data_i | input | 32 | Entry word returned |
| done_o | output | 1 | Walk finished pulse |
| fault_o | output | 2 | 0 none, 1 segmentation, 2 protection |
| fill_o | output | 1 | Insert translation / retry instruction |
| fill_vpn_o | output | 8 | Page number to insert |
| fill_pfn_o | output | 10 | Frame number to insert |
| fill_prot_o | output | 3 | Permission bits to insert |

## Verification
The bench builds the walker with its default parameters: a 14-bit virtual address, 64-byte pages, 4-byte entries and a 16-bit physical address. With these values the directory and table indices are each 4 bits wide, so the walks can hit directory slots 0 and 15 as well as the all-ones frame number 0x3FF, and every entry address stays inside the bench's small memory model. The response latency is varied from 1 to 7 cycles. This exercises the wait states at both levels, including a late miss strobe that arrives in the middle of a slow walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_WT_DIR,
    ST_RD_TBL,
    ST_WT_TBL
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_SEG  = 2'd1,
    FLT_PROT = 2'd2
  } fault_e;

  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_EX = 2'd2;

  // entry word field positions
  localparam int ENT_VALID_BIT = 0;
  localparam int ENT_PROT_LSB  = 1;
  localparam int ENT_PROT_W    = 3;
  localparam int ENT_PFN_LSB   = 8;
endpackage

// File: rtl/ptw_addr_calc.sv
module ptw_addr_calc #(
  parameter int VPN_W    = 8,
  parameter int DIR_W    = 4,
  parameter int TBL_W    = 4,
  parameter int OFF_W    = 6,
  parameter int PA_W     = 16,
  parameter int PFN_W    = 10,
  parameter int ENT_LOG2 = 2
) (
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [PA_W-1:0]  pdbr_i,
  input  logic [PFN_W-1:0] dir_pfn_i,
  output logic [PA_W-1:0]  pde_addr_o,
  output logic [PA_W-1:0]  pte_addr_o
);
  logic [DIR_W-1:0] dir_idx;
  logic [TBL_W-1:0] tbl_idx;

  assign dir_idx = vpn_i[VPN_W-1 -: DIR_W];
  assign tbl_idx = vpn_i[TBL_W-1:0];

  assign pde_addr_o = pdbr_i + (PA_W'(dir_idx) << ENT_LOG2);
  assign pte_addr_o = (PA_W'(dir_pfn_i) << OFF_W) + (PA_W'(tbl_idx) << ENT_LOG2);
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
#(
  parameter int ENT_W = 32,
  parameter int PFN_W = 10
) (
  input  logic [ENT_W-1:0]      entry_i,
  input  logic [1:0]            acc_i,
  output logic                  valid_o,
  output logic                  allowed_o,
  output logic [PFN_W-1:0]      pfn_o,
  output logic [ENT_PROT_W-1:0] prot_o
);
  logic unused_ok;

  assign valid_o = entry_i[ENT_VALID_BIT];
  assign prot_o  = entry_i[ENT_PROT_LSB +: ENT_PROT_W];
  assign pfn_o   = entry_i[ENT_PFN_LSB +: PFN_W];
  assign unused_ok = ^entry_i;

  always_comb begin
    case (acc_i)
      ACC_RD:  allowed_o = prot_o[0];
      ACC_WR:  allowed_o = prot_o[1];
      ACC_EX:  allowed_o = prot_o[2];
      default: allowed_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter  int VA_W      = 14,
  parameter  int PA_W      = 16,
  parameter  int OFF_W     = 6,
  parameter  int ENT_BYTES = 4,
  localparam int ENT_W     = 8 * ENT_BYTES,
  localparam int ENT_LOG2  = $clog2(ENT_BYTES),
  localparam int VPN_W     = VA_W - OFF_W,
  localparam int TBL_W     = OFF_W - ENT_LOG2,
  localparam int DIR_W     = VPN_W - TBL_W,
  localparam int PFN_W     = PA_W - OFF_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  miss_valid_i,
  input  logic [VPN_W-1:0]      miss_vpn_i,
  input  logic [1:0]            miss_acc_i,
  input  logic [PA_W-1:0]       pdbr_i,
  output logic                  busy_o,
  output logic                  mem_req_o,
  output logic [PA_W-1:0]       mem_addr_o,
  input  logic                  mem_rsp_valid_i,
  input  logic [ENT_W-1:0]      mem_rsp_data_i,
  output logic                  done_o,
  output logic [1:0]            fault_o,
  output logic                  fill_o,
  output logic [VPN_W-1:0]      fill_vpn_o,
  output logic [PFN_W-1:0]      fill_pfn_o,
  output logic [ENT_PROT_W-1:0] fill_prot_o
);
  walk_state_e           state;
  logic [VPN_W-1:0]      vpn_q;
  logic [1:0]            acc_q;
  logic [PA_W-1:0]       pdbr_q;
  logic [PFN_W-1:0]      dir_pfn_q;
  logic [PA_W-1:0]       pde_addr;
  logic [PA_W-1:0]       pte_addr;
  logic                  ent_valid;
  logic                  ent_allowed;
  logic [PFN_W-1:0]      ent_pfn;
  logic [ENT_PROT_W-1:0] ent_prot;

  ptw_addr_calc #(
    .VPN_W(VPN_W), .DIR_W(DIR_W), .TBL_W(TBL_W), .OFF_W(OFF_W),
    .PA_W(PA_W), .PFN_W(PFN_W), .ENT_LOG2(ENT_LOG2)
  ) u_addr (
    .vpn_i(vpn_q),
    .pdbr_i(pdbr_q),
    .dir_pfn_i(dir_pfn_q),
    .pde_addr_o(pde_addr),
    .pte_addr_o(pte_addr)
  );

  ptw_perm_check #(.ENT_W(ENT_W), .PFN_W(PFN_W)) u_perm (
    .entry_i(mem_rsp_data_i),
    .acc_i(acc_q),
    .valid_o(ent_valid),
    .allowed_o(ent_allowed),
    .pfn_o(ent_pfn),
    .prot_o(ent_prot)
  );

  assign busy_o = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      vpn_q       <= '0;
      acc_q       <= '0;
      pdbr_q      <= '0;
      dir_pfn_q   <= '0;
      mem_req_o   <= 1'b0;
      mem_addr_o  <= '0;
      done_o      <= 1'b0;
      fault_o     <= FLT_NONE;
      fill_o      <= 1'b0;
      fill_vpn_o  <= '0;
      fill_pfn_o  <= '0;
      fill_prot_o <= '0;
    end else begin
      mem_req_o <= 1'b0;
      done_o    <= 1'b0;
      fill_o    <= 1'b0;
      fault_o   <= FLT_NONE;
      case (state)
        ST_IDLE: begin
          if (miss_valid_i) begin
            vpn_q  <= miss_vpn_i;
            acc_q  <= miss_acc_i;
            pdbr_q <= pdbr_i;
            state  <= ST_RD_DIR;
          end
        end
        ST_RD_DIR: begin
          mem_req_o  <= 1'b1;
          mem_addr_o <= pde_addr;
          state      <= ST_WT_DIR;
        end
        ST_WT_DIR: begin
          if (mem_rsp_valid_i) begin
            if (!ent_valid) begin
              done_o  <= 1'b1;
              fault_o <= FLT_SEG;
              state   <= ST_IDLE;
            end else begin
              dir_pfn_q <= ent_pfn;
              state     <= ST_RD_TBL;
            end
          end
        end
        ST_RD_TBL: begin
          mem_req_o  <= 1'b1;
          mem_addr_o <= pte_addr;
          state      <= ST_WT_TBL;
        end
        ST_WT_TBL: begin
          if (mem_rsp_valid_i) begin
            done_o <= 1'b1;
            state  <= ST_IDLE;
            if (!ent_valid) begin
              fault_o <= FLT_SEG;
            end else if (!ent_allowed) begin
              fault_o <= FLT_PROT;
            end else begin
              fill_o      <= 1'b1;
              fill_vpn_o  <= vpn_q;
              fill_pfn_o  <= ent_pfn;
              fill_prot_o <= ent_prot;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy_o,
  input logic       mem_req_o,
  input logic       done_o,
  input logic [1:0] fault_o,
  input logic       fill_o
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);                                   // R8
  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    (fault_o != 2'd0) |-> done_o);                         // R8
  AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (rst)
    fill_o |-> (done_o && fault_o == 2'd0));               // R7
  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (rst)
    fault_o != 2'd3);                                      // R6
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |=> !mem_req_o);                             // R10
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> busy_o);                                 // R10
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);                                   // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!busy_o && !mem_req_o && !done_o && !fill_o)); // R1
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .mem_req_o(mem_req_o),
  .done_o(done_o), .fault_o(fault_o), .fill_o(fill_o)
);

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
  typedef struct packed {
    logic [7:0]  vpn;
    logic [1:0]  acc;
    logic [31:0] pde;
    logic [31:0] pte;
    logic [3:0]  lat;
    logic [1:0]  exp_fault;
  } vec_t;

  function automatic logic [31:0] mk(input logic [9:0] pfn, input logic [2:0] prot,
                                     input logic v);
    return (32'(pfn) << 8) | (32'(prot) << 1) | 32'(v);
  endfunction

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h23, 2'd0, mk(10'd5,  3'b000, 1'b1), mk(10'h02A, 3'b001, 1'b1), 4'd1, 2'd0},
    '{8'h7F, 2'd1, mk(10'd0,  3'b000, 1'b0), 32'h0,                      4'd3, 2'd1},
    '{8'h40, 2'd2, mk(10'd6,  3'b000, 1'b1), mk(10'd3,   3'b111, 1'b0), 4'd2, 2'd1},
    '{8'h5A, 2'd1, mk(10'd7,  3'b000, 1'b1), mk(10'd9,   3'b001, 1'b1), 4'd4, 2'd2},
    '{8'hFF, 2'd2, mk(10'd8,  3'b000, 1'b1), mk(10'h3FF, 3'b111, 1'b1), 4'd7, 2'd0},
    '{8'h00, 2'd0, mk(10'd9,  3'b000, 1'b1), mk(10'd4,   3'b010, 1'b1), 4'd1, 2'd2},
    '{8'h31, 2'd3, mk(10'd10, 3'b000, 1'b1), mk(10'd4,   3'b111, 1'b1), 4'd2, 2'd2},
    '{8'h12, 2'd1, mk(10'd11, 3'b000, 1'b1), mk(10'h155, 3'b011, 1'b1), 4'd5, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss_valid = 1'b0;
  logic [7:0]  miss_vpn = '0;
  logic [1:0]  miss_acc = '0;
  logic [15:0] pdbr = 16'h0100;
  logic        busy, mem_req, done, fill;
  logic [15:0] mem_addr;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic [1:0]  fault;
  logic [7:0]  fill_vpn;
  logic [9:0]  fill_pfn;
  logic [2:0]  fill_prot;

  ptw_walker u_ptw_walker (
    .clk(clk), .rst(rst),
    .miss_valid_i(miss_valid), .miss_vpn_i(miss_vpn), .miss_acc_i(miss_acc),
    .pdbr_i(pdbr), .busy_o(busy), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data),
    .done_o(done), .fault_o(fault), .fill_o(fill), .fill_vpn_o(fill_vpn),
    .fill_pfn_o(fill_pfn), .fill_prot_o(fill_prot)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] mem [0:255];
  int          cur_lat = 1;
  int          req_cnt = 0;
  logic [15:0] req_addr [0:3];
  int          last_rsp_cyc = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // memory model: one outstanding read, response after cur_lat cycles
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        if (req_cnt < 4) req_addr[req_cnt] = mem_addr;
        req_cnt++;
        repeat (cur_lat) @(negedge clk);
        rsp_valid = 1'b1;
        rsp_data  = mem[mem_addr[9:2]];
        last_rsp_cyc = cyc;
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_data  = '0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  logic [1:0] r_fault;
  logic       r_fill;
  logic [7:0] r_vpn;
  logic [9:0] r_pfn;
  logic [2:0] r_prot;
  int         r_done_cyc;
  bit         r_done_next;

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  // start a walk, optionally strobe a stray miss mid-walk, wait for done
  task automatic walk(input logic [7:0] vpn, input logic [1:0] acc, input int lat,
                      input bit stray);
    int t;
    cur_lat = lat;
    req_cnt = 0;
    @(negedge clk);
    miss_valid = 1'b1; miss_vpn = vpn; miss_acc = acc;
    @(negedge clk);
    miss_valid = 1'b0;
    check(busy == 1'b1, "R9 busy after accept", 32'(busy), 32'd1);
    if (stray) begin
      @(negedge clk);
      @(negedge clk);
      miss_valid = 1'b1; miss_vpn = 8'h99; miss_acc = 2'd1;
      @(negedge clk);
      miss_valid = 1'b0;
    end
    t = 0;
    while (!done && t < 1000) begin
      @(negedge clk);
      t++;
    end
    check(t < 1000, "R10 walk completes", 32'(t), 32'd0);
    r_fault = fault; r_fill = fill; r_vpn = fill_vpn; r_pfn = fill_pfn;
    r_prot = fill_prot; r_done_cyc = cyc;
    @(negedge clk);
    r_done_next = done;
  endtask

  initial begin
    logic [15:0] e_pde, e_pte;
    string tag;
    clear_mem();
    repeat (4) @(negedge clk);
    check(!busy && !mem_req && !done && !fill && fault == 2'd0, "R1 reset outputs",
          {27'd0, busy, mem_req, done, fill, |fault}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !mem_req && !done && !fill, "R1 idle after reset",
          {28'd0, busy, mem_req, done, fill}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      clear_mem();
      e_pde = pdbr + 16'(VECS[v].vpn[7:4]) * 16'd4;
      e_pte = (16'(VECS[v].pde[17:8]) << 6) + 16'(VECS[v].vpn[3:0]) * 16'd4;
      mem[e_pde[9:2]] = VECS[v].pde;
      if (VECS[v].pde[0]) mem[e_pte[9:2]] = VECS[v].pte;
      walk(VECS[v].vpn, VECS[v].acc, int'(VECS[v].lat), 1'b0);
      check(req_addr[0] == e_pde, "R2 directory address", 32'(req_addr[0]), 32'(e_pde));
      if (!VECS[v].pde[0]) begin
        check(req_cnt == 1, "R3 single read", 32'(req_cnt), 32'd1);
        tag = "R3 fault code";
      end else begin
        check(req_cnt == 2, "R10 two reads", 32'(req_cnt), 32'd2);
        check(req_addr[1] == e_pte, "R4 table address", 32'(req_addr[1]), 32'(e_pte));
        if (!VECS[v].pte[0]) tag = "R5 fault code";
        else if (VECS[v].exp_fault == 2'd2) tag = "R6 fault code";
        else tag = "R7 fault code";
      end
      check(r_fault == VECS[v].exp_fault, tag, 32'(r_fault), 32'(VECS[v].exp_fault));
      check(r_fill == (VECS[v].exp_fault == 2'd0), "R7 fill strobe", 32'(r_fill),
            32'(VECS[v].exp_fault == 2'd0));
      if (VECS[v].exp_fault == 2'd0) begin
        check(r_vpn == VECS[v].vpn, "R7 fill vpn", 32'(r_vpn), 32'(VECS[v].vpn));
        check(r_pfn == VECS[v].pte[17:8], "R7 fill pfn", 32'(r_pfn), 32'(VECS[v].pte[17:8]));
        check(r_prot == VECS[v].pte[3:1], "R7 fill prot", 32'(r_prot), 32'(VECS[v].pte[3:1]));
      end
      check(r_done_cyc == last_rsp_cyc + 1, "R8 done timing", 32'(r_done_cyc),
            32'(last_rsp_cyc + 1));
      check(r_done_next == 1'b0, "R8 done single cycle", 32'(r_done_next), 32'd0);
    end

    // R9: stray miss during a slow walk is ignored
    clear_mem();
    mem[(16'h0100 + 16'd8) >> 2]  = mk(10'd12, 3'b000, 1'b1);
    mem[(16'h0300 + 16'd12) >> 2] = mk(10'h0AB, 3'b001, 1'b1);
    walk(8'h23, 2'd0, 6, 1'b1);
    check(r_fill && r_vpn == 8'h23, "R9 stray miss ignored vpn", 32'(r_vpn), 32'h23);
    check(r_fault == 2'd0, "R9 stray miss no fault", 32'(r_fault), 32'd0);
    repeat (10) @(negedge clk);
    check(req_cnt == 2 && !busy, "R9 no extra walk", 32'(req_cnt), 32'd2);

    // R2: different directory base, captured at accept
    clear_mem();
    pdbr = 16'h0300;
    mem[(16'h0300 + 16'd8) >> 2]  = mk(10'd13, 3'b000, 1'b1);
    mem[(16'h0340 + 16'd12) >> 2] = mk(10'h111, 3'b100, 1'b1);
    cur_lat = 3;
    req_cnt = 0;
    @(negedge clk);
    miss_valid = 1'b1; miss_vpn = 8'h23; miss_acc = 2'd2;
    @(negedge clk);
    miss_valid = 1'b0;
    pdbr = 16'h0000;
    while (!done) @(negedge clk);
    check(req_addr[0] == 16'h0308, "R2 base captured", 32'(req_addr[0]), 32'h308);
    check(req_addr[1] == 16'h034C, "R4 second base", 32'(req_addr[1]), 32'h34C);
    check(fill && fill_pfn == 10'h111 && fill_prot == 3'b100, "R6 execute allowed",
          32'(fill_pfn), 32'h111);

    finish_run();
  end
endmodule